// File: doc/BRIEF.md
# Non-Restoring Single-Precision Divider

This unit divides one 32-bit single-precision value by another and returns the packed quotient. Each word holds a sign bit, an 8-bit biased exponent and a 23-bit fraction with an implied leading one. The significands are divided by a non-restoring shift/add-subtract loop that yields one quotient bit per clock. The result is then normalized by at most one position and rounded to nearest.

A one-cycle `start` pulse in the idle state captures both operands. Some cases need no division: a zero dividend, a zero divisor, or any operand that is not a normal number or zero. These are resolved at the accepting edge. Every other pair runs the full iteration loop. The unit answers with a one-cycle `done` pulse. `quotient` and `trap` then hold their values until the next result. A raised `trap` means the hardware could not produce a normal result, and the caller must handle the operation another way.

Top module: `fdiv_nr`

## Requirements
- R1: For any result without trap, the sign bit (bit 31) of `quotient` is the XOR of the two operand sign bits, and this includes zero results.
- R2: For normal operands, the exponent field (bits 30:23) is dividend exponent minus divisor exponent plus 127. It is one lower when the dividend significand is smaller than the divisor significand.
- R3: The fraction field (bits 22:0) is the exact significand quotient rounded to nearest, with ties to even. Any nonzero remainder counts as lying below the quotient bits when choosing the rounding direction.
- R4: For two normal operands, `done` rises after the 27th rising edge that follows the edge that sampled `start` (26 quotient steps plus one packing edge). For operands resolved without division, `done` rises at the sampling edge itself.
- R5: `done` is high for one cycle per result. `quotient` and `trap` keep their values until the next result.
- R6: A `start` pulse that arrives while a division is in progress is ignored. It yields no extra `done` and does not alter the running result.
- R7: A divisor that is zero (either sign) sets `trap`, and `quotient` is all zero.
- R8: A zero dividend with a normal divisor returns a zero with the XOR sign (0x00000000 or 0x80000000) and clears `trap`.
- R9: An operand whose exponent field is 255, or whose exponent field is 0 with a nonzero fraction, sets `trap` with `quotient` all zero.
- R10: After rounding, a final exponent above 254 or below 1 sets `trap` with `quotient` all zero. Exponents of exactly 254 and exactly 1 are returned normally.
- R11: While `rst_n` is low and after it is released, `done`, `trap` and `quotient` are zero until the first result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operand capture request, honoured only while idle |
| dividend | input | 32 | Numerator in single-precision format |
| divisor | input | 32 | Denominator in single-precision format |
| done | output | 1 | One-cycle result strobe |
| quotient | output | 32 | Packed rounded quotient, zero when trap is set |
| trap | output | 1 | Result not representable or operand not supported |

## Verification
The division path is tried with the following operand pairs:
- Equal significands, which give an exact quotient with no shift.
- Dividends whose significand is smaller than the divisor's, which forces the one-place normalization and the exponent decrement.
- Repeating quotients such as thirds, where a set guard bit must round up.
- Ratios just below one, where the remainder is nonzero but rounding must go down.

Sign mixes separate the XOR sign rule from magnitude errors. Exponent pairs that land on 1, 254, 0 and 255 separate the range check from the normalization step. A pseudo-random sweep is compared against a long-division model. That model uses integer quotient and remainder and shares nothing with the non-restoring loop. Each result's latency is also measured, which separates the early-exit path from the full iteration path.

// File: rtl/fdiv_pkg.sv
`timescale 1ns/1ps
package fdiv_pkg;

   // classification of one packed operand
   typedef enum logic [1:0] {
      CLS_ZERO = 2'd0,
      CLS_NORM = 2'd1,
      CLS_BAD  = 2'd2
   } opclass_t;

   // controller states of the divider
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } fsm_t;

endpackage

// File: rtl/fdiv_unpack.sv
`timescale 1ns/1ps
module fdiv_unpack
   import fdiv_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W,
   localparam int SIG_W = FRAC_W + 1
) (
   input  logic [W-1:0]     word,
   output logic             sgn,
   output logic [EXP_W-1:0] expo,
   output logic [SIG_W-1:0] sig,
   output opclass_t         cls
);

   logic [FRAC_W-1:0] frac;
   logic              exp_max;
   logic              exp_min;

   assign sgn  = word[W-1];
   assign expo = word[W-2 -: EXP_W];
   assign frac = word[FRAC_W-1:0];

   assign exp_max = &expo;
   assign exp_min = ~|expo;

   // hidden one restored for every normal operand
   assign sig = {1'b1, frac};

   always_comb begin
      if (exp_max)
         cls = CLS_BAD;
      else if (exp_min)
         cls = (|frac) ? CLS_BAD : CLS_ZERO;
      else
         cls = CLS_NORM;
   end

endmodule

// File: rtl/fdiv_nr_core.sv
`timescale 1ns/1ps
module fdiv_nr_core #(
   parameter int SIG_W  = 24,
   localparam int STEPS = SIG_W + 2,
   localparam int RW    = SIG_W + 2,
   localparam int CW    = $clog2(STEPS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SIG_W-1:0] dvd_sig,
   input  logic [SIG_W-1:0] dvs_sig,
   output logic [STEPS-1:0] quo,
   output logic             sticky,
   output logic             fin
);

   // Both significands sit under two zero bits, so the value range is
   // halved relative to the register and the doubled remainder cannot
   // run into the sign position.
   logic signed [RW-1:0] rem;
   logic signed [RW-1:0] dvs_r;
   logic signed [RW-1:0] rem_dbl;
   logic signed [RW-1:0] rem_next;
   logic signed [RW-1:0] rem_fix;
   logic [CW-1:0]        cnt;
   logic                 run;
   logic                 q_bit;
   logic                 last_step;

   assign rem_dbl   = rem <<< 1;
   assign q_bit     = ~rem[RW-1];
   assign last_step = (cnt == CW'(STEPS - 1));

   // a kept quotient bit is followed by a subtract, a dropped one by an add
   always_comb begin
      if (q_bit)
         rem_next = rem_dbl - dvs_r;
      else
         rem_next = rem_dbl + dvs_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem   <= '0;
         dvs_r <= '0;
         cnt   <= '0;
         run   <= 1'b0;
         fin   <= 1'b0;
         quo   <= '0;
      end else if (load) begin
         rem   <= $signed({2'b00, dvd_sig}) - $signed({2'b00, dvs_sig});
         dvs_r <= $signed({2'b00, dvs_sig});
         cnt   <= '0;
         run   <= 1'b1;
         fin   <= 1'b0;
         quo   <= '0;
      end else if (run) begin
         quo <= {quo[STEPS-2:0], q_bit};
         cnt <= cnt + 1'b1;
         if (last_step) begin
            run <= 1'b0;
            fin <= 1'b1;
         end else begin
            rem <= rem_next;
         end
      end else begin
         fin <= 1'b0;
      end
   end

   // remainder correction: a negative final remainder gets the divisor back
   assign rem_fix = rem[RW-1] ? (rem + dvs_r) : rem;
   assign sticky  = |rem_fix;

   // R3: the partial remainder always stays inside [-divisor, divisor)
   p_rem_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> ((rem + dvs_r) >= 0) && (rem < dvs_r));

endmodule

// File: rtl/fdiv_round_pack.sv
`timescale 1ns/1ps
module fdiv_round_pack #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int SIG_W = FRAC_W + 1,
   localparam int STEPS = SIG_W + 2,
   localparam int XW    = EXP_W + 2,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic                 sgn,
   input  logic signed [XW-1:0] exp_pre,
   input  logic [STEPS-1:0]     quo,
   input  logic                 sticky,
   output logic [W-1:0]         word,
   output logic                 range_err
);

   localparam logic signed [XW-1:0] EXP_TOP = XW'((2 ** EXP_W) - 2);
   localparam logic signed [XW-1:0] EXP_BOT = XW'(1);

   logic [SIG_W-1:0]     sig;
   logic [SIG_W:0]       sum;
   logic                 guard;
   logic                 low_any;
   logic                 bump;
   logic signed [XW-1:0] e_norm;
   logic signed [XW-1:0] e_fin;
   logic [FRAC_W-1:0]    frac;

   // at most one left shift: the leading one is in the top or next bit
   always_comb begin
      if (quo[STEPS-1]) begin
         sig     = quo[STEPS-1:2];
         guard   = quo[1];
         low_any = quo[0] | sticky;
         e_norm  = exp_pre;
      end else begin
         sig     = quo[STEPS-2:1];
         guard   = quo[0];
         low_any = sticky;
         e_norm  = exp_pre - XW'(1);
      end
   end

   // nearest, ties toward an even last bit
   assign bump = guard & (low_any | sig[0]);
   assign sum  = {1'b0, sig} + (SIG_W + 1)'(bump);

   // a carry out of the significand means it became exactly 2.0
   always_comb begin
      if (sum[SIG_W]) begin
         frac  = '0;
         e_fin = e_norm + XW'(1);
      end else begin
         frac  = sum[FRAC_W-1:0];
         e_fin = e_norm;
      end
   end

   assign range_err = (e_fin > EXP_TOP) || (e_fin < EXP_BOT);
   assign word      = range_err ? '0 : {sgn, e_fin[EXP_W-1:0], frac};

endmodule

// File: rtl/fdiv_nr.sv
`timescale 1ns/1ps
module fdiv_nr
   import fdiv_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W,
   localparam int SIG_W = FRAC_W + 1,
   localparam int STEPS = SIG_W + 2,
   localparam int XW    = EXP_W + 2,
   localparam int CW    = $clog2(STEPS + 1),
   localparam int BIAS  = (2 ** (EXP_W - 1)) - 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         done,
   output logic [W-1:0] quotient,
   output logic         trap
);

   generate
      if (EXP_W < 3 || FRAC_W < 3) begin : g_bad_size
         $error("fdiv_nr: exponent and fraction need at least 3 bits each");
      end
   endgenerate

   // ---------------- operand decode ----------------
   logic [W-1:0]     ops   [2];
   logic             u_sgn [2];
   logic [EXP_W-1:0] u_exp [2];
   logic [SIG_W-1:0] u_sig [2];
   opclass_t         u_cls [2];

   assign ops[0] = dividend;
   assign ops[1] = divisor;

   generate
      for (genvar gi = 0; gi < 2; gi++) begin : g_unpack
         fdiv_unpack #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
         ) u_unpack (
            .word (ops[gi]),
            .sgn  (u_sgn[gi]),
            .expo (u_exp[gi]),
            .sig  (u_sig[gi]),
            .cls  (u_cls[gi])
         );
      end
   endgenerate

   // ---------------- request qualification ----------------
   fsm_t                 state;
   logic                 accept;
   logic                 bad_in;
   logic                 zero_q;
   logic                 core_load;
   logic                 sgn_x;
   logic signed [XW-1:0] exp_pre_n;
   logic                 sgn_r;
   logic signed [XW-1:0] exp_r;

   assign accept    = start && (state == ST_IDLE);
   assign bad_in    = (u_cls[0] == CLS_BAD) || (u_cls[1] != CLS_NORM);
   assign zero_q    = (u_cls[0] == CLS_ZERO);
   assign core_load = accept && !bad_in && !zero_q;
   assign sgn_x     = u_sgn[0] ^ u_sgn[1];
   assign exp_pre_n = $signed({2'b00, u_exp[0]}) - $signed({2'b00, u_exp[1]})
                      + $signed(XW'(BIAS));

   // ---------------- iteration loop ----------------
   logic [STEPS-1:0] core_quo;
   logic             core_sticky;
   logic             core_fin;

   fdiv_nr_core #(
      .SIG_W (SIG_W)
   ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (core_load),
      .dvd_sig (u_sig[0]),
      .dvs_sig (u_sig[1]),
      .quo     (core_quo),
      .sticky  (core_sticky),
      .fin     (core_fin)
   );

   // ---------------- normalize, round, pack ----------------
   logic [W-1:0] pk_word;
   logic         pk_err;

   fdiv_round_pack #(
      .EXP_W  (EXP_W),
      .FRAC_W (FRAC_W)
   ) u_pack (
      .sgn       (sgn_r),
      .exp_pre   (exp_r),
      .quo       (core_quo),
      .sticky    (core_sticky),
      .word      (pk_word),
      .range_err (pk_err)
   );

   // ---------------- controller and result registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         done     <= 1'b0;
         quotient <= '0;
         trap     <= 1'b0;
         sgn_r    <= 1'b0;
         exp_r    <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  if (bad_in) begin
                     quotient <= '0;
                     trap     <= 1'b1;
                     done     <= 1'b1;
                  end else if (zero_q) begin
                     quotient <= {sgn_x, {(W-1){1'b0}}};
                     trap     <= 1'b0;
                     done     <= 1'b1;
                  end else begin
                     sgn_r <= sgn_x;
                     exp_r <= exp_pre_n;
                     state <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               if (core_fin) begin
                  quotient <= pk_word;
                  trap     <= pk_err;
                  done     <= 1'b1;
                  state    <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // ---------------- checks ----------------
   logic [CW-1:0] lat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lat_cnt <= '0;
      else if (core_load)
         lat_cnt <= '0;
      else if (state == ST_RUN)
         lat_cnt <= lat_cnt + 1'b1;
   end

   // R4: the loop reports completion after exactly STEPS clocks
   p_loop_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      core_fin |-> (lat_cnt == CW'(STEPS)));

   // R5: a result strobe lasts one cycle unless a new request is taken
   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);

   // R5: outputs only move when a result is presented
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(quotient) && $stable(trap)));

   // R7: a trapped result never carries a payload
   p_trap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && trap) |-> (quotient == '0));

   // R6: the loop is never restarted while it is running
   p_no_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN) |-> !core_load);

endmodule

// File: tb/fdiv_nr_bench.sv
`timescale 1ns/1ps
module fdiv_nr_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] dividend = '0;
   logic [31:0] divisor = '0;
   logic        done;
   logic [31:0] quotient;
   logic        trap;

   always #2 clk = ~clk;

   fdiv_nr u_fdiv_nr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .dividend (dividend),
      .divisor  (divisor),
      .done     (done),
      .quotient (quotient),
      .trap     (trap)
   );

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int pushed = 0;
   int popped = 0;
   bit finished = 0;

   logic [31:0] sb_q   [$];
   logic        sb_t   [$];
   int          sb_lat [$];
   int          sb_t0  [$];
   string       sb_tag [$];

   localparam int LAT_LOOP = 28;
   localparam int LAT_FAST = 1;

   always @(posedge clk) cyc <= cyc + 1;

   // independent model: integer long division of the scaled significands
   function automatic logic [32:0] ref_div(input logic [31:0] a, input logic [31:0] b);
      logic [7:0]  ea, eb;
      logic [22:0] fa, fb;
      logic        s, g, st;
      longint unsigned num, qq, rr, sg;
      int          e;
      ea = a[30:23]; fa = a[22:0];
      eb = b[30:23]; fb = b[22:0];
      s  = a[31] ^ b[31];
      if (ea == 8'hFF || eb == 8'hFF || (ea == 0 && fa != 0) || eb == 0)
         return {1'b1, 32'h0};
      if (ea == 0)
         return {1'b0, s, 31'h0};
      num = longint'({1'b1, fa}) << 25;
      qq  = num / longint'({1'b1, fb});
      rr  = num % longint'({1'b1, fb});
      e   = int'(ea) - int'(eb) + 127;
      if (qq[25]) begin
         sg = qq >> 2; g = qq[1]; st = qq[0] | (rr != 0);
      end else begin
         sg = (qq >> 1) & 64'hFFFFFF; g = qq[0]; st = (rr != 0); e = e - 1;
      end
      if (g && (st || sg[0])) sg = sg + 1;
      if (sg == 64'h1000000) begin
         sg = 64'h800000; e = e + 1;
      end
      if (e > 254 || e < 1) return {1'b1, 32'h0};
      return {1'b0, s, 8'(e), sg[22:0]};
   endfunction

   // monitor: pops one expectation per done strobe
   bit prev_done = 0;
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (prev_done) begin
            total++;
            if (done && !start) begin
               bad++;
               $display("FAIL R5 done stayed high: actual=1 expected=0");
            end
         end
         prev_done = done;
         if (done) begin
            if (sb_q.size() == 0) begin
               total++; bad++;
               $display("FAIL R6 unexpected done: actual=%h expected=none", quotient);
            end else begin
               logic [31:0] eq;
               logic        et;
               int          el, t0;
               string       tg;
               eq = sb_q.pop_front(); et = sb_t.pop_front();
               el = sb_lat.pop_front(); t0 = sb_t0.pop_front(); tg = sb_tag.pop_front();
               total++;
               if (quotient !== eq || trap !== et) begin
                  bad++;
                  $display("FAIL %s result: actual=%h/%b expected=%h/%b", tg, quotient, trap, eq, et);
               end
               total++;
               if ((cyc - t0) != el) begin
                  bad++;
                  $display("FAIL R4 latency (%s): actual=%0d expected=%0d", tg, cyc - t0, el);
               end
               popped++;
            end
         end
      end
   end

   // driver: pushes the expectation, pulses start, waits for the result
   task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] eq, input logic et,
                         input int lat, input string tg);
      @(negedge clk);
      dividend = a; divisor = b; start = 1'b1;
      sb_q.push_back(eq); sb_t.push_back(et); sb_lat.push_back(lat);
      sb_t0.push_back(cyc); sb_tag.push_back(tg);
      pushed++;
      @(negedge clk);
      start = 1'b0;
      while (popped < pushed) @(negedge clk);
      repeat (3) @(negedge clk);
      total++;
      if (quotient !== eq || trap !== et) begin
         bad++;
         $display("FAIL R5 hold (%s): actual=%h/%b expected=%h/%b", tg, quotient, trap, eq, et);
      end
   endtask

   task automatic run_model(input logic [31:0] a, input logic [31:0] b, input string tg);
      logic [32:0] r;
      r = ref_div(a, b);
      run_op(a, b, r[31:0], r[32], r[32] && (a[30:23] == 8'hFF || b[30:23] == 8'hFF
             || b[30:23] == 0 || (a[30:23] == 0 && a[22:0] != 0)) ? LAT_FAST :
             (a[30:23] == 0 ? LAT_FAST : LAT_LOOP), tg);
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL R4 watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      logic [31:0] ra, rb;
      lf = 32'h1357_9BDF;

      repeat (3) @(negedge clk);
      // R11: reset state
      total++;
      if (done !== 1'b0 || quotient !== 32'h0 || trap !== 1'b0) begin
         bad++;
         $display("FAIL R11 in reset: actual=%b/%h/%b expected=0/00000000/0", done, quotient, trap);
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      total++;
      if (done !== 1'b0 || quotient !== 32'h0 || trap !== 1'b0) begin
         bad++;
         $display("FAIL R11 after reset: actual=%b/%h/%b expected=0/00000000/0", done, quotient, trap);
      end

      // R2 exact quotients and exponent arithmetic
      run_op(32'h40C0_0000, 32'h4000_0000, 32'h4040_0000, 1'b0, LAT_LOOP, "R2 6/2");
      run_op(32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 1'b0, LAT_LOOP, "R2 1/1");
      // R3 rounding up on a set guard bit, rounding down otherwise
      run_op(32'h3F80_0000, 32'h4040_0000, 32'h3EAA_AAAB, 1'b0, LAT_LOOP, "R3 1/3");
      run_op(32'h4000_0000, 32'h4040_0000, 32'h3F2A_AAAB, 1'b0, LAT_LOOP, "R3 2/3");
      run_op(32'h4120_0000, 32'h4040_0000, 32'h4055_5555, 1'b0, LAT_LOOP, "R3 10/3");
      run_op(32'h3F80_0000, 32'h3F80_0001, 32'h3F7F_FFFE, 1'b0, LAT_LOOP, "R3 just below one");
      // R1 sign combinations
      run_op(32'hBF80_0000, 32'h4040_0000, 32'hBEAA_AAAB, 1'b0, LAT_LOOP, "R1 -1/3");
      run_op(32'h3F80_0000, 32'hBF80_0000, 32'hBF80_0000, 1'b0, LAT_LOOP, "R1 1/-1");
      run_op(32'hC000_0000, 32'hC000_0000, 32'h3F80_0000, 1'b0, LAT_LOOP, "R1 -2/-2");
      // R10 boundaries of the exponent range
      run_op(32'h7F00_0000, 32'h3F80_0000, 32'h7F00_0000, 1'b0, LAT_LOOP, "R10 top edge");
      run_op(32'h7F7F_FFFF, 32'h3F80_0000, 32'h7F7F_FFFF, 1'b0, LAT_LOOP, "R10 largest");
      run_op(32'h0080_0000, 32'h3F80_0000, 32'h0080_0000, 1'b0, LAT_LOOP, "R10 bottom edge");
      run_op(32'h0100_0000, 32'h3FC0_0000, 32'h00AA_AAAB, 1'b0, LAT_LOOP, "R2 shifted to bottom");
      run_op(32'h0080_0000, 32'h3FC0_0000, 32'h0000_0000, 1'b1, LAT_LOOP, "R10 underflow");
      run_op(32'h7F00_0000, 32'h0080_0000, 32'h0000_0000, 1'b1, LAT_LOOP, "R10 overflow");
      run_op(32'h7F7F_FFFF, 32'h3F00_0000, 32'h0000_0000, 1'b1, LAT_LOOP, "R10 overflow by one");
      // R8 zero dividend
      run_op(32'h0000_0000, 32'hC000_0000, 32'h8000_0000, 1'b0, LAT_FAST, "R8 +0/-2");
      run_op(32'h8000_0000, 32'hC000_0000, 32'h0000_0000, 1'b0, LAT_FAST, "R8 -0/-2");
      run_op(32'h8000_0000, 32'h4000_0000, 32'h8000_0000, 1'b0, LAT_FAST, "R8 -0/2");
      // R7 zero divisor
      run_op(32'h3F80_0000, 32'h0000_0000, 32'h0000_0000, 1'b1, LAT_FAST, "R7 x/+0");
      run_op(32'hBF80_0000, 32'h8000_0000, 32'h0000_0000, 1'b1, LAT_FAST, "R7 x/-0");
      run_op(32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b1, LAT_FAST, "R7 0/0");
      // R9 unsupported operands
      run_op(32'h7FC0_0000, 32'h3F80_0000, 32'h0000_0000, 1'b1, LAT_FAST, "R9 nan dividend");
      run_op(32'h3F80_0000, 32'h7F80_0000, 32'h0000_0000, 1'b1, LAT_FAST, "R9 inf divisor");
      run_op(32'h0000_0001, 32'h3F80_0000, 32'h0000_0000, 1'b1, LAT_FAST, "R9 denormal dividend");
      run_op(32'h3F80_0000, 32'h0040_0000, 32'h0000_0000, 1'b1, LAT_FAST, "R9 denormal divisor");
      run_op(32'h0000_0000, 32'hFF80_0000, 32'h0000_0000, 1'b1, LAT_FAST, "R9 zero by inf");

      // R6: a second start in mid-run must be dropped
      @(negedge clk);
      dividend = 32'h4120_0000; divisor = 32'h4040_0000; start = 1'b1;
      sb_q.push_back(32'h4055_5555); sb_t.push_back(1'b0); sb_lat.push_back(LAT_LOOP);
      sb_t0.push_back(cyc); sb_tag.push_back("R6 busy start");
      pushed++;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      dividend = 32'h3F80_0000; divisor = 32'h0000_0000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      dividend = 32'h4000_0000; divisor = 32'h4000_0000;
      while (popped < pushed) @(negedge clk);
      repeat (40) @(negedge clk);
      total++;
      if (popped != pushed || sb_q.size() != 0) begin
         bad++;
         $display("FAIL R6 result count: actual=%0d expected=%0d", popped, pushed);
      end

      // R3 sweep against the long-division model
      for (int i = 0; i < 48; i++) begin
         lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
         ra = {lf[31], 8'(8'd100 + {3'b000, lf[27:23]}), lf[22:0]};
         lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
         rb = {lf[31], 8'(8'd110 + {3'b000, lf[27:23]}), lf[22:0]};
         run_model(ra, rb, "R3 sweep");
      end

      finished = 1;
      summary();
      $finish;
   end

endmodule